// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps the coherence state of a small direct-mapped cache that shares a snooped bus with other caches. It tracks each line as Modified, Exclusive, Shared or Invalid. It turns local processor accesses into bus read or read-for-ownership requests, and it reacts to read and read-for-ownership traffic it observes from other caches. The Exclusive state lets a sole reader start writing later without a second bus transaction.

The wired-OR sharing line decides the fill state on a read miss. The block drives its own contribution to that line combinationally whenever a snooped address matches one of its valid lines. Several caches can hold the same clean block. A daisy chain, with the lowest index first, makes sure that only one of them supplies the block. A cache passes the chain on as claimed once it holds the snooped block. A snooped command takes the lookup port in its cycle, and the processor is held off for that cycle.

All bus-facing outputs are combinational from the current inputs and the registered line state. A new line state is visible from the next cycle through the state lookup output.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. `pr_state_o` reports Invalid (encoding I=0, S=1, E=2, M=3), and `bus_req_o` and `flush_o` are low while inputs are idle.
- R2: A processor read that misses raises `bus_req_o` in the same cycle with `bus_cmd_o`=0 (read) and `bus_addr_o`=`pr_addr`. If `shared_i` is low in that cycle, the line holds state E from the next cycle.
- R3: A read miss that sees `shared_i` high fills the line in state S.
- R4: A processor write to an E line makes it M with no bus request. Reads that hit M, E or S, and writes that hit M, make no bus request and do not change the state.
- R5: A processor write to an S line, or a write that misses, raises `bus_req_o` with `bus_cmd_o`=1 (read for ownership). The line holds state M with the new tag from the next cycle.
- R6: `shared_o` is high in exactly the cycles in which `snp_valid` is high and `snp_addr` matches the tag of a valid line.
- R7: A snooped read (`snp_cmd`=0) that hits M or E asserts `flush_o` with `flush_addr_o`=`snp_addr` in that cycle. The line becomes S.
- R8: A snooped read for ownership (`snp_cmd`=1) that hits any valid line makes it Invalid. It asserts `flush_o` when the line was M or E.
- R9: `chain_o` = `chain_i` OR snoop hit. A line in S supplies `flush_o` on a snooped hit only when `chain_i` is low.
- R10: A processor miss that replaces an M line asserts `flush_o` in the same cycle as its bus request. `flush_addr_o` carries the victim's tag and index.
- R11: `pr_ready_o` is low exactly while `snp_valid` is high. A processor request in such a cycle is ignored: it makes no bus request and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pr_req | input | 1 | Processor access request |
| pr_we | input | 1 | 1 = write, 0 = read |
| pr_addr | input | ADDR_W | Processor block address |
| pr_ready_o | output | 1 | Processor access accepted this cycle |
| pr_state_o | output | 2 | State of pr_addr's block in this cache (I if absent) |
| bus_req_o | output | 1 | Bus request this cycle |
| bus_cmd_o | output | 1 | 0 = read, 1 = read for ownership |
| bus_addr_o | output | ADDR_W | Requested block address |
| shared_i | input | 1 | Wired-OR sharing line from other caches |
| snp_valid | input | 1 | Snooped bus command present |
| snp_cmd | input | 1 | 0 = read, 1 = read for ownership |
| snp_addr | input | ADDR_W | Snooped block address |
| shared_o | output | 1 | This cache holds the snooped block |
| chain_i | input | 1 | A lower-index cache already holds the snooped block |
| chain_o | output | 1 | Chain passed to the next cache |
| flush_o | output | 1 | Supply / write-back strobe |
| flush_addr_o | output | ADDR_W | Address of the flushed block |

## Verification
Bus request, command, address, the sharing and chain outputs and the flush strobe are all due in the same cycle as the stimulus that causes them. A line's new state shows on `pr_state_o` one cycle later. The bench applies each stimulus just after a falling edge and compares every output against a behavioural line-state model shortly afterwards, before the next rising edge. It then advances the model exactly as that rising edge advances the design. The next lookup therefore reads the state that edge wrote, so every registered result is checked in the cycle it first becomes visible.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
   typedef enum logic [1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_E = 2'd2,
      ST_M = 2'd3
   } line_st_t;

   localparam logic CMD_RD  = 1'b0;
   localparam logic CMD_RDX = 1'b1;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
   import mesi_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int TAG_W     = 9,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [IDX_W-1:0]      ra_idx,
   output line_st_t              ra_st,
   output logic [TAG_W-1:0]      ra_tag,
   input  logic [IDX_W-1:0]      rb_idx,
   output line_st_t              rb_st,
   output logic [TAG_W-1:0]      rb_tag,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  line_st_t              wr_st,
   input  logic [TAG_W-1:0]      wr_tag,
   output line_st_t [NUM_LINES-1:0] st_all
);
   logic [TAG_W-1:0] tag_all [NUM_LINES];

   initial begin
      assert (NUM_LINES >= 2 && (1 << IDX_W) == NUM_LINES)
         else $error("NUM_LINES must be a power of two, at least 2");
      assert (TAG_W >= 1) else $error("TAG_W must be positive");
   end

   for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
      line_st_t         st_r;
      logic [TAG_W-1:0] tag_r;
      logic             sel;
      assign sel = wr_en && (wr_idx == IDX_W'(gi));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_r  <= ST_I;
            tag_r <= '0;
         end else if (sel) begin
            st_r  <= wr_st;
            tag_r <= wr_tag;
         end
      end
      assign st_all[gi]  = st_r;
      assign tag_all[gi] = tag_r;
   end

   assign ra_st  = st_all[ra_idx];
   assign ra_tag = tag_all[ra_idx];
   assign rb_st  = st_all[rb_idx];
   assign rb_tag = tag_all[rb_idx];
endmodule

// File: rtl/mesi_pr_path.sv
module mesi_pr_path
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 3,
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  line_st_t          cur_st,
   input  logic [TAG_W-1:0]  cur_tag,
   input  logic              shared_i,
   output logic              hit,
   output logic              bus_req,
   output logic              bus_cmd,
   output logic              victim_flush,
   output logic [ADDR_W-1:0] victim_addr,
   output logic              upd_en,
   output line_st_t          upd_st,
   output logic [TAG_W-1:0]  upd_tag
);
   logic [TAG_W-1:0] req_tag;
   logic [IDX_W-1:0] req_idx;
   logic             dirty_victim;

   assign req_tag      = addr[ADDR_W-1:IDX_W];
   assign req_idx      = addr[IDX_W-1:0];
   assign hit          = (cur_st != ST_I) && (cur_tag == req_tag);
   assign dirty_victim = !hit && (cur_st == ST_M);
   assign victim_addr  = {cur_tag, req_idx};

   always_comb begin
      bus_req      = 1'b0;
      bus_cmd      = CMD_RD;
      victim_flush = 1'b0;
      upd_en       = 1'b0;
      upd_st       = cur_st;
      upd_tag      = req_tag;
      if (req) begin
         if (we) begin
            if (hit && (cur_st == ST_M || cur_st == ST_E)) begin
               upd_en = 1'b1;
               upd_st = ST_M;
            end else begin
               bus_req      = 1'b1;
               bus_cmd      = CMD_RDX;
               victim_flush = dirty_victim;
               upd_en       = 1'b1;
               upd_st       = ST_M;
            end
         end else if (!hit) begin
            bus_req      = 1'b1;
            bus_cmd      = CMD_RD;
            victim_flush = dirty_victim;
            upd_en       = 1'b1;
            upd_st       = shared_i ? ST_S : ST_E;
         end
      end
   end
endmodule

// File: rtl/mesi_snoop_path.sv
module mesi_snoop_path
   import mesi_pkg::*;
#(
   parameter int TAG_W        = 9,
   parameter bit SUPPLY_CLEAN = 1'b1
) (
   input  logic             valid,
   input  logic             cmd,
   input  logic [TAG_W-1:0] snp_tag,
   input  line_st_t         cur_st,
   input  logic [TAG_W-1:0] cur_tag,
   input  logic             chain_i,
   output logic             hit,
   output logic             chain_o,
   output logic             flush,
   output logic             upd_en,
   output line_st_t         upd_st
);
   logic clean_supply;

   assign hit     = valid && (cur_st != ST_I) && (cur_tag == snp_tag);
   assign chain_o = chain_i || hit;

   if (SUPPLY_CLEAN) begin : g_clean_supply
      assign clean_supply = (cur_st == ST_E) || (cur_st == ST_S && !chain_i);
   end else begin : g_dirty_only
      assign clean_supply = 1'b0;
   end

   assign flush = hit && ((cur_st == ST_M) || clean_supply);

   always_comb begin
      upd_en = 1'b0;
      upd_st = cur_st;
      if (hit) begin
         if (cmd == CMD_RDX) begin
            upd_en = 1'b1;
            upd_st = ST_I;
         end else if (cur_st != ST_S) begin
            upd_en = 1'b1;
            upd_st = ST_S;
         end
      end
   end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
   import mesi_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int NUM_LINES    = 8,
   parameter bit SUPPLY_CLEAN = 1'b1,
   localparam int IDX_W       = $clog2(NUM_LINES),
   localparam int TAG_W       = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pr_req,
   input  logic              pr_we,
   input  logic [ADDR_W-1:0] pr_addr,
   output logic              pr_ready_o,
   output logic [1:0]        pr_state_o,
   output logic              bus_req_o,
   output logic              bus_cmd_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   input  logic              shared_i,
   input  logic              snp_valid,
   input  logic              snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              shared_o,
   input  logic              chain_i,
   output logic              chain_o,
   output logic              flush_o,
   output logic [ADDR_W-1:0] flush_addr_o
);
   initial begin
      assert (ADDR_W > IDX_W) else $error("ADDR_W must exceed the index width");
   end

   logic [IDX_W-1:0] p_idx, s_idx;
   line_st_t         p_st, s_st;
   logic [TAG_W-1:0] p_tag, s_tag;
   line_st_t [NUM_LINES-1:0] st_all;

   logic             pr_fire, p_hit, p_breq, p_bcmd, p_vflush, p_upd;
   logic [ADDR_W-1:0] p_vaddr;
   line_st_t         p_upd_st;
   logic [TAG_W-1:0] p_upd_tag;

   logic             s_hit, s_flush, s_upd;
   line_st_t         s_upd_st;

   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   line_st_t         wr_st;
   logic [TAG_W-1:0] wr_tag;

   assign p_idx   = pr_addr[IDX_W-1:0];
   assign s_idx   = snp_addr[IDX_W-1:0];
   assign pr_fire = pr_req && !snp_valid;

   mesi_line_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .ra_idx (p_idx),
      .ra_st  (p_st),
      .ra_tag (p_tag),
      .rb_idx (s_idx),
      .rb_st  (s_st),
      .rb_tag (s_tag),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_st  (wr_st),
      .wr_tag (wr_tag),
      .st_all (st_all)
   );

   mesi_pr_path #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_pr (
      .req          (pr_fire),
      .we           (pr_we),
      .addr         (pr_addr),
      .cur_st       (p_st),
      .cur_tag      (p_tag),
      .shared_i     (shared_i),
      .hit          (p_hit),
      .bus_req      (p_breq),
      .bus_cmd      (p_bcmd),
      .victim_flush (p_vflush),
      .victim_addr  (p_vaddr),
      .upd_en       (p_upd),
      .upd_st       (p_upd_st),
      .upd_tag      (p_upd_tag)
   );

   mesi_snoop_path #(.TAG_W(TAG_W), .SUPPLY_CLEAN(SUPPLY_CLEAN)) u_snp (
      .valid   (snp_valid),
      .cmd     (snp_cmd),
      .snp_tag (snp_addr[ADDR_W-1:IDX_W]),
      .cur_st  (s_st),
      .cur_tag (s_tag),
      .chain_i (chain_i),
      .hit     (s_hit),
      .chain_o (chain_o),
      .flush   (s_flush),
      .upd_en  (s_upd),
      .upd_st  (s_upd_st)
   );

   // snooped commands own the single write port
   always_comb begin
      if (s_upd) begin
         wr_en  = 1'b1;
         wr_idx = s_idx;
         wr_st  = s_upd_st;
         wr_tag = s_tag;
      end else begin
         wr_en  = p_upd;
         wr_idx = p_idx;
         wr_st  = p_upd_st;
         wr_tag = p_upd_tag;
      end
   end

   assign pr_ready_o   = !snp_valid;
   assign pr_state_o   = p_hit ? p_st : ST_I;
   assign bus_req_o    = p_breq;
   assign bus_cmd_o    = p_bcmd;
   assign bus_addr_o   = pr_addr;
   assign shared_o     = s_hit;
   assign flush_o      = s_flush || p_vflush;
   assign flush_addr_o = s_flush ? snp_addr : p_vaddr;

   AST_EXCL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_fire && !pr_we && bus_req_o && !shared_i) |=> st_all[$past(p_idx)] == ST_E); // R2
   AST_SHARED_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_fire && !pr_we && bus_req_o && shared_i) |=> st_all[$past(p_idx)] == ST_S); // R3
   AST_SILENT_UPGRADE: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_fire && pr_we && pr_state_o == ST_E) |-> !bus_req_o); // R4
   AST_UPGRADE_TO_M: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_fire && pr_we) |=> st_all[$past(p_idx)] == ST_M); // R5
   AST_SHARED_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      shared_o |-> snp_valid); // R6
   AST_READX_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_cmd && shared_o) |=> st_all[$past(s_idx)] == ST_I); // R8
   AST_CHAIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      chain_i |-> chain_o); // R9
   AST_SNOOP_STALLS_PR: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !bus_req_o); // R11
endmodule

// File: tb/sim_mesi_snoop_ctrl.sv
module sim_mesi_snoop_ctrl;
   localparam int AW = 12;
   localparam int NL = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pr_req = 0, pr_we = 0, shared_i = 0, snp_valid = 0, snp_cmd = 0, chain_i = 0;
   logic [AW-1:0] pr_addr = '0, snp_addr = '0;
   logic pr_ready_o, bus_req_o, bus_cmd_o, shared_o, chain_o, flush_o;
   logic [1:0] pr_state_o;
   logic [AW-1:0] bus_addr_o, flush_addr_o;

   int checks = 0, errors = 0;
   int mst[NL];
   int mtag[NL];

   always #2 clk = ~clk;

   mesi_snoop_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .pr_req(pr_req), .pr_we(pr_we), .pr_addr(pr_addr),
      .pr_ready_o(pr_ready_o), .pr_state_o(pr_state_o), .bus_req_o(bus_req_o),
      .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o), .shared_i(shared_i),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .shared_o(shared_o), .chain_i(chain_i), .chain_o(chain_o),
      .flush_o(flush_o), .flush_addr_o(flush_addr_o)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one cycle: drive, compare with model, advance model as the next edge does
   task automatic step(string req, bit rq, bit we, int pa, bit sv, bit sc, int sa, bit shi, bit chi);
      int pidx, ptg, sidx, stg, e_pst, e_fl, e_fa, e_br, e_cmd, st0;
      bit shit;
      @(negedge clk);
      pr_req = rq; pr_we = we; pr_addr = AW'(pa);
      snp_valid = sv; snp_cmd = sc; snp_addr = AW'(sa);
      shared_i = shi; chain_i = chi;
      #1;
      pidx = pa % NL; ptg = pa / NL; sidx = sa % NL; stg = sa / NL;
      e_pst = (mst[pidx] != 0 && mtag[pidx] == ptg) ? mst[pidx] : 0;
      shit = sv && mst[sidx] != 0 && mtag[sidx] == stg;
      e_fl = 0; e_fa = 0; e_br = 0; e_cmd = 0;
      if (shit) begin
         st0 = mst[sidx];
         e_fl = (st0 >= 2 || (st0 == 1 && !chi)) ? 1 : 0;
         e_fa = sa;
         mst[sidx] = sc ? 0 : 1;
      end else if (rq && !sv) begin
         if (we) begin
            if (e_pst >= 2) mst[pidx] = 3;
            else begin
               e_br = 1; e_cmd = 1;
               if (e_pst == 0 && mst[pidx] == 3) begin e_fl = 1; e_fa = mtag[pidx] * NL + pidx; end
               mst[pidx] = 3; mtag[pidx] = ptg;
            end
         end else if (e_pst == 0) begin
            e_br = 1; e_cmd = 0;
            if (mst[pidx] == 3) begin e_fl = 1; e_fa = mtag[pidx] * NL + pidx; end
            mst[pidx] = shi ? 1 : 2; mtag[pidx] = ptg;
         end
      end
      chk(req, "pr_state", pr_state_o, e_pst);
      chk(req, "ready", pr_ready_o, !sv);
      chk(req, "shared_o", shared_o, shit);
      chk(req, "chain_o", chain_o, chi || shit);
      chk(req, "bus_req", bus_req_o, e_br);
      if (e_br) begin
         chk(req, "bus_cmd", bus_cmd_o, e_cmd);
         chk(req, "bus_addr", bus_addr_o, pa);
      end
      chk(req, "flush", flush_o, e_fl);
      if (e_fl) chk(req, "flush_addr", flush_addr_o, e_fa);
   endtask

   function automatic int A(int tg, int ix);
      return tg * NL + ix;
   endfunction

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NL; i++) begin mst[i] = 0; mtag[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset leaves everything Invalid
      for (int i = 0; i < NL; i++) step("R1", 0, 0, A(1, i), 0, 0, 0, 0, 0);
      // R2: read miss, no sharer -> E
      step("R2", 1, 0, A(1, 0), 0, 0, 0, 0, 0);
      step("R2", 0, 0, A(1, 0), 0, 0, 0, 0, 0);
      // R4: silent E -> M, then hits on M stay quiet
      step("R4", 1, 1, A(1, 0), 0, 0, 0, 0, 0);
      step("R4", 1, 0, A(1, 0), 0, 0, 0, 0, 0);
      step("R4", 1, 1, A(1, 0), 0, 0, 0, 0, 0);
      // R7: snooped read on M flushes and demotes
      step("R7", 0, 0, A(1, 0), 1, 0, A(1, 0), 0, 0);
      // R9: S holder with chain claimed stays silent, then supplies
      step("R9", 0, 0, A(1, 0), 1, 0, A(1, 0), 0, 1);
      step("R9", 0, 0, A(1, 0), 1, 0, A(1, 0), 0, 0);
      // R5: write to S -> read for ownership, M
      step("R5", 1, 1, A(1, 0), 0, 0, 0, 0, 0);
      step("R5", 0, 0, A(1, 0), 0, 0, 0, 0, 0);
      // R10 with R3: miss replacing M, sharer present -> victim flush, S
      step("R10", 1, 0, A(2, 0), 0, 0, 0, 1, 0);
      step("R3", 0, 0, A(2, 0), 0, 0, 0, 0, 0);
      step("R4", 1, 0, A(2, 0), 0, 0, 0, 0, 0);
      // R8: read for ownership on S with chain claimed -> Invalid, no flush
      step("R8", 0, 0, 0, 1, 1, A(2, 0), 0, 1);
      step("R8", 0, 0, A(2, 0), 0, 0, 0, 0, 0);
      // R8: E line snooped for ownership flushes
      step("R2", 1, 0, A(3, 1), 0, 0, 0, 0, 0);
      step("R8", 0, 0, 0, 1, 1, A(3, 1), 0, 0);
      step("R8", 0, 0, A(3, 1), 0, 0, 0, 0, 0);
      // R7: snooped read on E flushes and demotes to S
      step("R2", 1, 0, A(4, 2), 0, 0, 0, 0, 0);
      step("R7", 0, 0, 0, 1, 0, A(4, 2), 0, 0);
      step("R7", 0, 0, A(4, 2), 0, 0, 0, 0, 0);
      // R6: snoop with tag mismatch is not a hit
      step("R6", 0, 0, 0, 1, 0, A(5, 2), 0, 0);
      // R11: processor write during snoop is ignored
      step("R11", 1, 1, A(6, 3), 1, 0, A(7, 4), 0, 0);
      step("R11", 0, 0, A(6, 3), 0, 0, 0, 0, 0);
      // R5: write miss
      step("R5", 1, 1, A(6, 3), 0, 0, 0, 0, 0);
      step("R5", 0, 0, A(6, 3), 0, 0, 0, 0, 0);
      // mixed traffic against the model
      for (int n = 0; n < 2000; n++) begin
         int r;
         r = $urandom;
         step("R6", (r & 1) != 0, (r & 2) != 0, int'(($urandom % 4) * NL + ($urandom % 3)),
              (r & 12) == 12, (r & 16) != 0, int'(($urandom % 4) * NL + ($urandom % 3)),
              (r & 32) != 0, (r & 64) != 0);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule